// File: doc/BRIEF.md
# Reset and Clock-Release Sequencer

This block decides when a chip leaves reset and when its system clock may be used. Each reset request arrives with a cause code. The block then runs a chain of timed phases whose make-up depends on that cause and on a regulator strap. In parallel it runs a clock chain, which waits for the strobes that belong to the selected oscillator class:

- an RC start-up done pulse,
- a PLL lock pulse,
- a crystal start-up count that runs on the raw oscillator input.

The system reset is released only once both chains have finished.

The request also samples a two-speed start-up enable. When it is set, the system first runs from the fast RC oscillator, which needs only its own start-up pulse. The primary source then keeps starting in the background. The active-source indication moves to the primary source once that source is ready, and reset is not asserted again. A new request during any phase restarts both chains from the first phase that applies to the new inputs. All phase lengths are parameters in reference clock cycles, except the crystal count, which is a fixed power of two of oscillator periods.

Top module: `rst_clk_seq`

## Requirements
- R1: After the block reset `rst_n`, `sys_rst_rel` and `clk_valid` are 0 and `act_src` shows the fast RC code 1, until a request completes.
- R2: For cause code 1 (power-on), the reset chain lasts T_POR + T_RST + T_PWRT reference cycles when `vreg_off` is 1, and T_POR + T_RST when it is 0. The count starts at the clock edge that samples `rst_req`.
- R3: For cause code 2 (brown-out), the reset chain lasts T_RST + T_PWRT cycles when `vreg_off` is 1, and T_RST cycles when it is 0.
- R4: For cause codes 0 and 3, the reset chain lasts T_RST cycles whatever the value of `vreg_off`.
- R5: `sys_rst_rel` rises in the cycle after the later of two events: the reset chain ending, or the clock becoming valid.
- R6: The clock-source codes and what each one waits for:
  - 0 (external clock) and 7 wait for nothing.
  - 1 (fast RC) and 2 (low-power RC) wait for one `rc_ready` pulse.
  - 3 (external clock with PLL) waits for one `pll_lock` pulse.
  - Pulses are counted from the second cycle after the request.
- R7: Code 4 (fast RC with PLL) waits for `rc_ready` and then `pll_lock`. A lock pulse that arrives before the RC pulse is ignored.
- R8: Codes 5 (crystal or secondary oscillator) and 6 (crystal with PLL) wait for 2^OST_W rising edges of `osc_clk`, counted after a two-flop synchronizer. The finish flag returns through a two-flop synchronizer. Code 6 then also waits for `pll_lock`, and lock pulses that arrive earlier are ignored.
- R9: With `two_speed_en` set, the clock becomes valid after `rc_ready` alone, and `act_src` shows 1, whatever source is selected.
- R10: Under two-speed start-up, `act_src` switches to the selected code once that source's crystal count and lock (where they apply) have completed. `sys_rst_rel` stays 1 throughout, and only a new request lowers it.
- R11: A request lowers `sys_rst_rel` and `clk_valid` in the following cycle. Timing then restarts from the new request, and a crystal count already under way is restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference timing clock |
| osc_clk | input | 1 | Raw crystal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_req | input | 1 | One-cycle request that samples the inputs below and restarts the sequence |
| rst_cause | input | 2 | Reset cause: 1 power-on, 2 brown-out, 0/3 other |
| clk_sel | input | 3 | Selected clock-source code |
| two_speed_en | input | 1 | Start on fast RC first |
| vreg_off | input | 1 | On-chip regulator disabled (enables power-up timer phase) |
| rc_ready | input | 1 | RC oscillator start-up done pulse |
| pll_lock | input | 1 | PLL lock pulse |
| sys_rst_rel | output | 1 | System reset released |
| clk_valid | output | 1 | System clock may be used |
| act_src | output | 3 | Clock source currently driving the system |

## Verification
The assertions check the following on every cycle:
- a request pulls down release and clock-valid in the next cycle;
- release, once high, stays high until a request arrives;
- `act_src` changes away from a request only by leaving the fast RC code while the clock is valid;
- the reset-phase counter stays below the length of its phase;
- the crystal finish flag rises only after the counter has reached its top value.

Only the bench scenarios show the actual reset-chain lengths for each cause and strap, the wait for each clock source, the rejection of early lock pulses, the restart of the crystal count, and the timing of the source switch under two-speed start-up.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  localparam logic [2:0] SRC_EXT     = 3'd0;
  localparam logic [2:0] SRC_FRC     = 3'd1;
  localparam logic [2:0] SRC_LPRC    = 3'd2;
  localparam logic [2:0] SRC_EXTPLL  = 3'd3;
  localparam logic [2:0] SRC_FRCPLL  = 3'd4;
  localparam logic [2:0] SRC_XTAL    = 3'd5;
  localparam logic [2:0] SRC_XTALPLL = 3'd6;

  localparam logic [1:0] CAUSE_POR = 2'd1;
  localparam logic [1:0] CAUSE_BOR = 2'd2;

  typedef enum logic [2:0] {
    RP_IDLE, RP_POR, RP_RST, RP_PWRT, RP_DONE
  } rphase_e;

  typedef enum logic [2:0] {
    CP_IDLE, CP_INIT, CP_RC, CP_OST, CP_LOCK, CP_UP
  } cphase_e;

  // Wait mask of a clock source: bit0 RC start, bit1 crystal count, bit2 PLL lock
  function automatic logic [2:0] src_needs(input logic [2:0] s);
    case (s)
      SRC_FRC, SRC_LPRC: return 3'b001;
      SRC_EXTPLL:        return 3'b100;
      SRC_FRCPLL:        return 3'b101;
      SRC_XTAL:          return 3'b010;
      SRC_XTALPLL:       return 3'b110;
      default:           return 3'b000;
    endcase
  endfunction

  // First wait phase strictly after cur that the mask asks for
  function automatic cphase_e next_cphase(input cphase_e cur, input logic [2:0] m);
    logic rc_ok, ost_ok, lock_ok;
    rc_ok   = (cur == CP_IDLE) || (cur == CP_INIT);
    ost_ok  = rc_ok || (cur == CP_RC);
    lock_ok = ost_ok || (cur == CP_OST);
    if (rc_ok && m[0])        return CP_RC;
    else if (ost_ok && m[1])  return CP_OST;
    else if (lock_ok && m[2]) return CP_LOCK;
    else                      return CP_UP;
  endfunction

  // Reset-chain phase order for a cause and regulator strap
  function automatic rphase_e next_rphase(input rphase_e cur, input logic [1:0] cause,
                                          input logic vreg_off);
    logic por, bor;
    por = (cause == CAUSE_POR);
    bor = (cause == CAUSE_BOR);
    case (cur)
      RP_IDLE: return por ? RP_POR : RP_RST;
      RP_POR:  return RP_RST;
      RP_RST:  return ((por || bor) && vreg_off) ? RP_PWRT : RP_DONE;
      default: return RP_DONE;
    endcase
  endfunction

endpackage

// File: rtl/rcs_sync2.sv
module rcs_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rcs_reset_chain.sv
module rcs_reset_chain
  import rcs_pkg::*;
#(
  parameter int unsigned T_POR  = 2048,
  parameter int unsigned T_RST  = 64,
  parameter int unsigned T_PWRT = 64000,
  localparam int unsigned TMAX  = (T_POR > T_RST) ? ((T_POR > T_PWRT) ? T_POR : T_PWRT)
                                                  : ((T_RST > T_PWRT) ? T_RST : T_PWRT),
  localparam int unsigned CW    = $clog2(TMAX + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    cause,
  input  logic          vreg_off,
  output logic          done,
  output rphase_e       phase,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] len
);
  logic [1:0] cause_q;
  logic       vreg_q;
  logic       last;

  always_comb begin
    case (phase)
      RP_POR:  len = CW'(T_POR);
      RP_RST:  len = CW'(T_RST);
      RP_PWRT: len = CW'(T_PWRT);
      default: len = '0;
    endcase
  end

  assign last = (cnt == len - CW'(1));
  assign done = (phase == RP_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= RP_IDLE;
      cnt     <= '0;
      cause_q <= 2'd0;
      vreg_q  <= 1'b0;
    end else if (start) begin
      cause_q <= cause;
      vreg_q  <= vreg_off;
      phase   <= next_rphase(RP_IDLE, cause, vreg_off);
      cnt     <= '0;
    end else if (phase != RP_IDLE && phase != RP_DONE) begin
      if (last) begin
        phase <= next_rphase(phase, cause_q, vreg_q);
        cnt   <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/rcs_ost_counter.sv
module rcs_ost_counter #(
  parameter int unsigned OST_W = 10
)(
  input  logic             clk,
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             run,
  output logic             busy_s,
  output logic             done_s,
  output logic [OST_W-1:0] ost_cnt,
  output logic             ost_flag
);
  logic run_o;
  logic busy_o;

  rcs_sync2 u_run_sync (.clk(osc_clk), .rst_n(rst_n), .d(run), .q(run_o));

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      ost_cnt  <= '0;
      ost_flag <= 1'b0;
    end else if (!run_o) begin
      ost_cnt  <= '0;
      ost_flag <= 1'b0;
    end else if (!ost_flag) begin
      if (&ost_cnt) ost_flag <= 1'b1;
      ost_cnt <= ost_cnt + 1'b1;
    end
  end

  assign busy_o = run_o | ost_flag;

  rcs_sync2 u_busy_sync (.clk(clk), .rst_n(rst_n), .d(busy_o),   .q(busy_s));
  rcs_sync2 u_done_sync (.clk(clk), .rst_n(rst_n), .d(ost_flag), .q(done_s));
endmodule

// File: rtl/rcs_clk_chain.sv
module rcs_clk_chain
  import rcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] sel,
  input  logic       two_speed,
  input  logic       rc_ready,
  input  logic       pll_lock,
  input  logic       ost_busy_s,
  input  logic       ost_done_s,
  output logic       ost_run,
  output logic       clk_valid,
  output logic [2:0] act_src,
  output cphase_e    phase
);
  logic [2:0] sel_q;
  logic       ts_q;
  logic       on_frc;
  logic [2:0] cur_mask;
  logic       ev;
  cphase_e    nxt;
  cphase_e    stage2_first;

  always_comb begin
    if (ts_q && !on_frc) cur_mask = 3'b001;
    else                 cur_mask = src_needs(sel_q);
    case (phase)
      CP_INIT: ev = !ost_busy_s;
      CP_RC:   ev = rc_ready;
      CP_OST:  ev = ost_done_s;
      CP_LOCK: ev = pll_lock;
      default: ev = 1'b0;
    endcase
    nxt          = next_cphase(phase, cur_mask);
    stage2_first = next_cphase(CP_RC, src_needs(sel_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= CP_IDLE;
      sel_q  <= SRC_FRC;
      ts_q   <= 1'b0;
      on_frc <= 1'b0;
    end else if (start) begin
      phase  <= CP_INIT;
      sel_q  <= sel;
      ts_q   <= two_speed;
      on_frc <= 1'b0;
    end else if (ev) begin
      if (nxt == CP_UP && ts_q && !on_frc) begin
        phase  <= stage2_first;
        on_frc <= (stage2_first != CP_UP);
      end else begin
        phase <= nxt;
        if (nxt == CP_UP) on_frc <= 1'b0;
      end
    end
  end

  assign ost_run   = (phase == CP_OST);
  assign clk_valid = (phase == CP_UP) || on_frc;
  assign act_src   = (ts_q && phase != CP_UP) ? SRC_FRC : sel_q;
endmodule

// File: rtl/rst_clk_seq.sv
module rst_clk_seq
  import rcs_pkg::*;
#(
  parameter int unsigned T_POR  = 2048,
  parameter int unsigned T_RST  = 64,
  parameter int unsigned T_PWRT = 64000,
  parameter int unsigned OST_W  = 10,
  localparam int unsigned TMAX  = (T_POR > T_RST) ? ((T_POR > T_PWRT) ? T_POR : T_PWRT)
                                                  : ((T_RST > T_PWRT) ? T_RST : T_PWRT),
  localparam int unsigned CW    = $clog2(TMAX + 1)
)(
  input  logic       clk,
  input  logic       osc_clk,
  input  logic       rst_n,
  input  logic       rst_req,
  input  logic [1:0] rst_cause,
  input  logic [2:0] clk_sel,
  input  logic       two_speed_en,
  input  logic       vreg_off,
  input  logic       rc_ready,
  input  logic       pll_lock,
  output logic       sys_rst_rel,
  output logic       clk_valid,
  output logic [2:0] act_src
);
  logic             r_done;
  rphase_e          r_phase;
  logic [CW-1:0]    r_cnt;
  logic [CW-1:0]    r_len;
  cphase_e          c_phase;
  logic             ost_run;
  logic             ost_busy_s;
  logic             ost_done_s;
  logic [OST_W-1:0] ost_cnt;
  logic             ost_flag;

  rcs_reset_chain #(.T_POR(T_POR), .T_RST(T_RST), .T_PWRT(T_PWRT)) u_rchain (
    .clk(clk), .rst_n(rst_n), .start(rst_req), .cause(rst_cause), .vreg_off(vreg_off),
    .done(r_done), .phase(r_phase), .cnt(r_cnt), .len(r_len)
  );

  rcs_ost_counter #(.OST_W(OST_W)) u_ost (
    .clk(clk), .osc_clk(osc_clk), .rst_n(rst_n), .run(ost_run),
    .busy_s(ost_busy_s), .done_s(ost_done_s), .ost_cnt(ost_cnt), .ost_flag(ost_flag)
  );

  rcs_clk_chain u_cchain (
    .clk(clk), .rst_n(rst_n), .start(rst_req), .sel(clk_sel), .two_speed(two_speed_en),
    .rc_ready(rc_ready), .pll_lock(pll_lock), .ost_busy_s(ost_busy_s),
    .ost_done_s(ost_done_s), .ost_run(ost_run), .clk_valid(clk_valid),
    .act_src(act_src), .phase(c_phase)
  );

  assign sys_rst_rel = r_done && clk_valid;
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker
  import rcs_pkg::*;
#(
  parameter int unsigned CW    = 8,
  parameter int unsigned OST_W = 10
)(
  input logic             clk,
  input logic             osc_clk,
  input logic             rst_n,
  input logic             rst_req,
  input logic             sys_rst_rel,
  input logic             clk_valid,
  input logic [2:0]       act_src,
  input rphase_e          r_phase,
  input logic [CW-1:0]    r_cnt,
  input logic [CW-1:0]    r_len,
  input logic [OST_W-1:0] ost_cnt,
  input logic             ost_flag
);
  // R11
  req_drops_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (!sys_rst_rel && !clk_valid));

  // R10
  release_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_rel && !rst_req) |=> sys_rst_rel);

  // R9
  src_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_src) && !$past(rst_req)) |-> ($past(act_src) == SRC_FRC && clk_valid));

  // R2
  phase_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_phase != RP_IDLE && r_phase != RP_DONE) |-> (r_cnt < r_len));

  // R8
  ost_span_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(ost_flag) |-> (&$past(ost_cnt)));
endmodule

bind rst_clk_seq rcs_checker #(.CW(CW), .OST_W(OST_W)) i_rcs_checker (
  .clk(clk), .osc_clk(osc_clk), .rst_n(rst_n), .rst_req(rst_req),
  .sys_rst_rel(sys_rst_rel), .clk_valid(clk_valid), .act_src(act_src),
  .r_phase(r_phase), .r_cnt(r_cnt), .r_len(r_len),
  .ost_cnt(ost_cnt), .ost_flag(ost_flag)
);

// File: tb/test_rst_clk_seq.sv
module test_rst_clk_seq;
  localparam int TP = 20, TR = 10, TW = 30;

  logic clk = 1'b0, osc_clk = 1'b0, rst_n = 1'b0;
  logic rst_req = 1'b0, two_speed_en = 1'b0, vreg_off = 1'b0;
  logic rc_ready = 1'b0, pll_lock = 1'b0;
  logic [1:0] rst_cause = 2'd0;
  logic [2:0] clk_sel = 3'd0;
  logic sys_rst_rel, clk_valid;
  logic [2:0] act_src;

  always #4 clk = ~clk;
  always #5 osc_clk = ~osc_clk;

  rst_clk_seq #(.T_POR(TP), .T_RST(TR), .T_PWRT(TW), .OST_W(10)) i_rst_clk_seq (
    .clk(clk), .osc_clk(osc_clk), .rst_n(rst_n), .rst_req(rst_req),
    .rst_cause(rst_cause), .clk_sel(clk_sel), .two_speed_en(two_speed_en),
    .vreg_off(vreg_off), .rc_ready(rc_ready), .pll_lock(pll_lock),
    .sys_rst_rel(sys_rst_rel), .clk_valid(clk_valid), .act_src(act_src)
  );

  typedef struct {
    int lo;
    int hi;
    logic [2:0] src;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0, since = 0;
  bit finished = 0;
  logic rel_prev = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // cycle counter since the last sampled request
  always @(posedge clk) begin
    if (rst_req) since <= 0;
    else         since <= since + 1;
  end

  // monitor: compare each release edge against the scoreboard
  always @(negedge clk) begin
    if (rst_n && sys_rst_rel && !rel_prev) begin
      if (exp_q.size() == 0) begin
        check(0, "unexpected release", since, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(since >= e.lo && since <= e.hi, {e.tag, " release cycle"}, since, e.lo);
        check(act_src == e.src, {e.tag, " act_src at release"}, int'(act_src), int'(e.src));
      end
    end
    rel_prev <= sys_rst_rel;
  end

  task automatic issue(input logic [1:0] cause, input logic [2:0] sel, input logic ts,
                       input logic vreg);
    @(negedge clk);
    rst_cause = cause; clk_sel = sel; two_speed_en = ts; vreg_off = vreg;
    rst_req = 1'b1;
  endtask

  task automatic do_seq(input logic [1:0] cause, input logic [2:0] sel, input logic ts,
                        input logic vreg, input int rc1, input int lk1, input int lk2,
                        input int lo, input int hi, input logic [2:0] esrc,
                        input int ca, input logic [2:0] sa, input int cb,
                        input logic [2:0] sb, input int run_n, input string tag);
    exp_t e;
    e.lo = lo; e.hi = hi; e.src = esrc; e.tag = tag;
    exp_q.push_back(e);
    issue(cause, sel, ts, vreg);
    for (int c = 1; c <= run_n; c++) begin
      @(negedge clk);
      rst_req  = 1'b0;
      rc_ready = (c == rc1);
      pll_lock = (c == lk1) || (c == lk2);
      if (c == 1) check(!sys_rst_rel && !clk_valid, "R11 request drops release", sys_rst_rel, 0);
      if (c == ca) begin
        check(act_src == sa, "R10 act_src", int'(act_src), int'(sa));
        check(sys_rst_rel, "R10 release held", sys_rst_rel, 1);
      end
      if (c == cb) begin
        check(act_src == sb, "R10 act_src after switch", int'(act_src), int'(sb));
        check(sys_rst_rel, "R10 release held after switch", sys_rst_rel, 1);
      end
    end
    @(negedge clk);
    rc_ready = 1'b0; pll_lock = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic idle_run(input int n);
    for (int c = 1; c <= n; c++) begin
      @(negedge clk);
      rst_req = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(!sys_rst_rel, "R1 sys_rst_rel", sys_rst_rel, 0);
    check(!clk_valid, "R1 clk_valid", clk_valid, 0);
    check(act_src == 3'd1, "R1 act_src", int'(act_src), 1);

    // R2 power-on, with and without power-up timer
    do_seq(2'd1, 3'd0, 0, 1, -1, -1, -1, TP+TR+TW, TP+TR+TW, 3'd0, -1, 0, -1, 0, 70, "R2 por vreg_off");
    do_seq(2'd1, 3'd0, 0, 0, -1, -1, -1, TP+TR, TP+TR, 3'd0, -1, 0, -1, 0, 40, "R2 por vreg_on");
    // R3 brown-out
    do_seq(2'd2, 3'd0, 0, 1, -1, -1, -1, TR+TW, TR+TW, 3'd0, -1, 0, -1, 0, 45, "R3 bor vreg_off");
    do_seq(2'd2, 3'd0, 0, 0, -1, -1, -1, TR, TR, 3'd0, -1, 0, -1, 0, 15, "R3 bor vreg_on");
    // R4 other causes ignore the strap
    do_seq(2'd0, 3'd0, 0, 1, -1, -1, -1, TR, TR, 3'd0, -1, 0, -1, 0, 15, "R4 other code0");
    do_seq(2'd3, 3'd7, 0, 1, -1, -1, -1, TR, TR, 3'd7, -1, 0, -1, 0, 15, "R4 R6 other code3 src7");
    // R5 R6 late RC start holds release
    do_seq(2'd0, 3'd1, 0, 0, 25, -1, -1, 25, 25, 3'd1, -1, 0, -1, 0, 30, "R5 R6 frc late rc");
    do_seq(2'd2, 3'd2, 0, 0, 5, -1, -1, TR, TR, 3'd2, -1, 0, -1, 0, 15, "R6 lprc early rc");
    do_seq(2'd0, 3'd3, 0, 0, -1, 40, -1, 40, 40, 3'd3, -1, 0, -1, 0, 45, "R6 extpll lock");
    // R7 lock before RC is ignored
    do_seq(2'd0, 3'd4, 0, 0, 8, 3, 50, 50, 50, 3'd4, -1, 0, -1, 0, 55, "R7 frcpll order");
    // R8 crystal count
    do_seq(2'd0, 3'd5, 0, 0, -1, -1, -1, 1280, 1295, 3'd5, -1, 0, -1, 0, 1300, "R8 xtal count");
    // R11 restart mid chain with a new cause
    issue(2'd1, 3'd1, 0, 1);
    idle_run(30);
    check(!sys_rst_rel, "R11 no release before restart", sys_rst_rel, 0);
    do_seq(2'd0, 3'd0, 0, 0, -1, -1, -1, TR, TR, 3'd0, -1, 0, -1, 0, 15, "R11 restart other");
    // R11 R8 restart of a running crystal count
    issue(2'd0, 3'd5, 0, 0);
    idle_run(100);
    do_seq(2'd0, 3'd5, 0, 0, -1, -1, -1, 1280, 1300, 3'd5, -1, 0, -1, 0, 1310, "R11 xtal restart");
    // R9 R10 two-speed with crystal plus PLL, early lock ignored
    do_seq(2'd1, 3'd6, 1, 1, 4, 500, 1400, TP+TR+TW, TP+TR+TW, 3'd1, 600, 3'd1, 1402, 3'd6,
           1410, "R9 two-speed frc first");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule